// File: doc/BRIEF.md
# Flash Block Protection Unit

This unit keeps the protection state of an on-chip flash array and judges every access against it. The array is divided into protection granules (2 KB by default). Each granule owns one read-permit bit and one program-permit bit. The bits are grouped into permit words, one bit per granule. There are four banks, and each bank has one read-permit word and one program-permit word. The granule number is the access address divided by the granule size. Its low five bits pick the bit inside a word. The next two bits pick the bank, so addresses above the fourth bank wrap onto the first.

Software reads and writes the live permit words through a simple register port. Each write is combined with the current value by bitwise AND, so a write can only tighten protection. An access-check port takes an address and an access kind and answers at once with allow or violation. A registered violation flag follows one cycle later.

A keyed commit request copies one live word into a non-volatile shadow word. A reset reloads every live word from its shadow, so uncommitted changes are lost and committed ones persist. A factory-blank input returns the shadow to all ones, which is the read/write state for every granule.

Top module: `fbp_unit`

## Requirements
- R1: After `nv_blank` has been applied and a reset has followed, all eight permit words read back as 32'hFFFFFFFF, and every access kind is allowed everywhere.
- R2: A register write at index `reg_idx` sets that live word to old AND `reg_wdata`. A 1 in `reg_wdata` never sets a bit that is already 0. The new value is visible on `reg_rdata` in the cycle after the write edge. Index encoding: `reg_idx[2]` = 0 selects the read-permit word and 1 selects the program-permit word; `reg_idx[1:0]` is the bank.
- R3: An instruction fetch (`chk_type` = 0) is always allowed, whatever the permit bits hold.
- R4: A data read (`chk_type` = 1) is allowed only when the granule's read-permit bit is 1.
- R5: A program (`chk_type` = 2) or erase (`chk_type` = 3) is allowed only when both permit bits of the granule are 1. Read-only (read 1, program 0) and execute-only (read 0, program either value) granules refuse it. This includes read 0 with program 1.
- R6: Granule = `chk_addr` / 2048. Bank = (granule / 32) mod 4. Bit = granule mod 32. Addresses beyond the fourth bank alias onto banks 0 to 3.
- R7: With `chk_valid` high, exactly one of `chk_allow` and `chk_violation` is high in the same cycle. With `chk_valid` low, both are low. `viol_flag` is high in the cycle after the edge at which a violation was present, and low otherwise.
- R8: A commit with `commit_key` = 16'hC3A5 copies the live word at `commit_idx` (same encoding as R2) into its shadow and pulses `commit_ack` in the next cycle. A commit with any other key changes no shadow word and gives no acknowledge.
- R9: A reset reloads every live word from its shadow, so register writes that were not committed are undone.
- R10: `nv_blank` sets every shadow word to all ones. The live words take this value at the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; reloads live words from the shadow |
| nv_blank | input | 1 | Returns the non-volatile shadow to its erased all-ones state |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index: bit 2 selects the word kind, bits 1:0 the bank |
| reg_wdata | input | 32 | Write data, ANDed into the selected live word |
| reg_rdata | output | 32 | Live word selected by `reg_idx` |
| commit_req | input | 1 | Commit request strobe |
| commit_idx | input | 3 | Register index to commit |
| commit_key | input | 16 | Commit key; must equal 16'hC3A5 |
| commit_ack | output | 1 | Pulses one cycle after an accepted commit |
| chk_valid | input | 1 | Access check request |
| chk_addr | input | 32 | Byte address of the access |
| chk_type | input | 2 | 0 fetch, 1 data read, 2 program, 3 erase |
| chk_allow | output | 1 | Access permitted |
| chk_violation | output | 1 | Access refused |
| viol_flag | output | 1 | Registered violation indication |

## Verification
The access check is tried with all four access kinds against granules in each of the protection states. These states are read/write, read-only, execute-only with the program bit clear, and execute-only with the program bit still set. This separates a decoder that looks only at the read bit from one that looks only at the program bit. Addresses above the fourth bank are checked against the aliased bank to confirm the modulo mapping rather than a saturating one. Writes with all-ones data show that bits cannot be set again. Commits with good and bad keys, each followed by a reset, show which changes persist. A long pseudo-random mix of writes, commits and checks is compared against a behavioural model on every cycle.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_DREAD = 2'd1,
      ACC_PROG  = 2'd2,
      ACC_ERASE = 2'd3
   } acc_kind_e;

   localparam logic [15:0] COMMIT_KEY_DEF = 16'hC3A5;

   // Access rule: fetch needs nothing, data read needs the read bit,
   // program and erase need both bits.
   function automatic logic acc_permitted(acc_kind_e kind, logic rd_ok, logic pg_ok);
      logic res;
      case (kind)
         ACC_FETCH: res = 1'b1;
         ACC_DREAD: res = rd_ok;
         default:   res = rd_ok & pg_ok;
      endcase
      return res;
   endfunction

endpackage

// File: rtl/fbp_store.sv
// Live permit words plus their non-volatile shadow copies.
module fbp_store #(
   parameter int              NUM_REGS = 8,
   parameter int              DATA_W   = 32,
   parameter int              IDX_W    = 3,
   parameter int              KEY_W    = 16,
   parameter logic [KEY_W-1:0] KEY     = '1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             nv_blank,
   input  logic                             wr_en,
   input  logic [IDX_W-1:0]                 wr_idx,
   input  logic [DATA_W-1:0]                wr_data,
   input  logic                             cm_req,
   input  logic [IDX_W-1:0]                 cm_idx,
   input  logic [KEY_W-1:0]                 cm_key,
   output logic                             cm_ack,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  words
);

   logic cm_hit;
   assign cm_hit = rst_n & cm_req & (cm_key == KEY);

   if (NUM_REGS > (1 << IDX_W)) begin : g_bad_idx
      $error("fbp_store: IDX_W too narrow for NUM_REGS");
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
      logic [DATA_W-1:0] live_q;
      logic [DATA_W-1:0] shadow_q;

      // Shadow: untouched by rst_n, only blank or keyed commit change it.
      always_ff @(posedge clk) begin
         if (nv_blank) begin
            shadow_q <= '1;
         end else if (cm_hit && (cm_idx == IDX_W'(g))) begin
            shadow_q <= live_q;
         end
      end

      // Live word: reloaded on reset, only ever tightened by writes.
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            live_q <= shadow_q;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            live_q <= live_q & wr_data;
         end
      end

      assign words[g] = live_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cm_ack <= 1'b0;
      end else begin
         cm_ack <= cm_hit;
      end
   end

endmodule

// File: rtl/fbp_locate.sv
// Address to bank / bit position decode.
module fbp_locate #(
   parameter int ADDR_W  = 32,
   parameter int GRAN_LG = 11,
   parameter int BLK_LG  = 5,
   parameter int BANK_LG = 2
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [BANK_LG-1:0] bank,
   output logic [BLK_LG-1:0]  bit_sel
);

   localparam int USED_HI = GRAN_LG + BLK_LG + BANK_LG;

   if (USED_HI > ADDR_W) begin : g_bad_addr
      $error("fbp_locate: address too narrow for granule and bank layout");
   end

   assign bit_sel = addr[GRAN_LG +: BLK_LG];
   assign bank    = addr[GRAN_LG + BLK_LG +: BANK_LG];

   // Offset bits inside a granule and aliasing high bits do not matter.
   if (USED_HI < ADDR_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:USED_HI];
   end
   if (GRAN_LG > 0) begin : g_lo
      logic unused_lo;
      assign unused_lo = ^addr[GRAN_LG-1:0];
   end

endmodule

// File: rtl/fbp_judge.sv
// Selects the two permit bits of a granule and applies the access rule.
module fbp_judge
   import fbp_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int DATA_W    = 32,
   parameter int BANK_LG   = 2,
   parameter int BLK_LG    = 5
) (
   input  logic [2*NUM_BANKS-1:0][DATA_W-1:0] words,
   input  logic [BANK_LG-1:0]                 bank,
   input  logic [BLK_LG-1:0]                  bit_sel,
   input  acc_kind_e                          kind,
   input  logic                               valid,
   output logic                               allow,
   output logic                               violation
);

   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] pg_word;
   logic              ok;

   assign rd_word = words[{1'b0, bank}];
   assign pg_word = words[{1'b1, bank}];
   assign ok      = acc_permitted(kind, rd_word[bit_sel], pg_word[bit_sel]);

   assign allow     = valid & ok;
   assign violation = valid & ~ok;

endmodule

// File: rtl/fbp_unit.sv
module fbp_unit
   import fbp_pkg::*;
#(
   parameter int               ADDR_W    = 32,
   parameter int               DATA_W    = 32,
   parameter int               NUM_BANKS = 4,
   parameter int               GRANULE   = 2048,
   parameter int               KEY_W     = 16,
   parameter logic [KEY_W-1:0] KEY       = COMMIT_KEY_DEF,
   localparam int              BANK_LG   = $clog2(NUM_BANKS),
   localparam int              IDX_W     = BANK_LG + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nv_blank,
   input  logic              reg_wr,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              commit_req,
   input  logic [IDX_W-1:0]  commit_idx,
   input  logic [KEY_W-1:0]  commit_key,
   output logic              commit_ack,
   input  logic              chk_valid,
   input  logic [ADDR_W-1:0] chk_addr,
   input  logic [1:0]        chk_type,
   output logic              chk_allow,
   output logic              chk_violation,
   output logic              viol_flag
);

   localparam int GRAN_LG  = $clog2(GRANULE);
   localparam int BLK_LG   = $clog2(DATA_W);
   localparam int NUM_REGS = 2 * NUM_BANKS;

   if ((1 << GRAN_LG) != GRANULE) begin : g_bad_gran
      $error("fbp_unit: GRANULE must be a power of two");
   end
   if ((1 << BLK_LG) != DATA_W) begin : g_bad_width
      $error("fbp_unit: DATA_W must be a power of two");
   end
   if (NUM_BANKS < 2 || (1 << BANK_LG) != NUM_BANKS) begin : g_bad_banks
      $error("fbp_unit: NUM_BANKS must be a power of two, at least 2");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] words;
   logic [BANK_LG-1:0]              bank;
   logic [BLK_LG-1:0]               bit_sel;

   fbp_store #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .KEY_W    (KEY_W),
      .KEY      (KEY)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .nv_blank (nv_blank),
      .wr_en    (reg_wr),
      .wr_idx   (reg_idx),
      .wr_data  (reg_wdata),
      .cm_req   (commit_req),
      .cm_idx   (commit_idx),
      .cm_key   (commit_key),
      .cm_ack   (commit_ack),
      .words    (words)
   );

   fbp_locate #(
      .ADDR_W  (ADDR_W),
      .GRAN_LG (GRAN_LG),
      .BLK_LG  (BLK_LG),
      .BANK_LG (BANK_LG)
   ) u_locate (
      .addr    (chk_addr),
      .bank    (bank),
      .bit_sel (bit_sel)
   );

   fbp_judge #(
      .NUM_BANKS (NUM_BANKS),
      .DATA_W    (DATA_W),
      .BANK_LG   (BANK_LG),
      .BLK_LG    (BLK_LG)
   ) u_judge (
      .words     (words),
      .bank      (bank),
      .bit_sel   (bit_sel),
      .kind      (acc_kind_e'(chk_type)),
      .valid     (chk_valid),
      .allow     (chk_allow),
      .violation (chk_violation)
   );

   assign reg_rdata = words[reg_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         viol_flag <= 1'b0;
      end else begin
         viol_flag <= chk_violation;
      end
   end

endmodule

// File: rtl/fbp_unit_chk.sv
module fbp_unit_chk #(
   parameter int               ADDR_W = 32,
   parameter int               DATA_W = 32,
   parameter int               IDX_W  = 3,
   parameter int               KEY_W  = 16,
   parameter logic [KEY_W-1:0] KEY    = 16'hC3A5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [IDX_W-1:0]  reg_idx,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              commit_req,
   input logic [KEY_W-1:0]  commit_key,
   input logic              commit_ack,
   input logic              chk_valid,
   input logic [ADDR_W-1:0] chk_addr,
   input logic [1:0]        chk_type,
   input logic              chk_allow,
   input logic              chk_violation,
   input logic              viol_flag
);

   logic unused_addr;
   assign unused_addr = ^chk_addr;

   p_tighten_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && $past(rst_n)) |=> ((reg_idx != $past(reg_idx)) ||
                   (reg_rdata == ($past(reg_rdata) & $past(reg_wdata)))));

   p_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && chk_type == 2'd0) |-> chk_allow);

   p_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |-> $onehot({chk_allow, chk_violation}));

   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |-> (!chk_allow && !chk_violation));

   p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      chk_violation |=> viol_flag);

   p_flag_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_violation |=> !viol_flag);

   p_ack_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit_ack |-> ($past(commit_req) && $past(commit_key) == KEY));

endmodule

bind fbp_unit fbp_unit_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .IDX_W  (IDX_W),
   .KEY_W  (KEY_W),
   .KEY    (KEY)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_wr        (reg_wr),
   .reg_idx       (reg_idx),
   .reg_wdata     (reg_wdata),
   .reg_rdata     (reg_rdata),
   .commit_req    (commit_req),
   .commit_key    (commit_key),
   .commit_ack    (commit_ack),
   .chk_valid     (chk_valid),
   .chk_addr      (chk_addr),
   .chk_type      (chk_type),
   .chk_allow     (chk_allow),
   .chk_violation (chk_violation),
   .viol_flag     (viol_flag)
);

// File: tb/test_fbp_unit.sv
module test_fbp_unit;

   localparam logic [15:0] GOOD_KEY = 16'hC3A5;

   logic        clk = 1'b0;
   logic        rst_n, nv_blank, reg_wr, commit_req, chk_valid;
   logic [2:0]  reg_idx, commit_idx;
   logic [31:0] reg_wdata, reg_rdata, chk_addr;
   logic [15:0] commit_key;
   logic [1:0]  chk_type;
   logic        commit_ack, chk_allow, chk_violation, viol_flag;

   always #5 clk = ~clk;

   fbp_unit i_fbp_unit (
      .clk(clk), .rst_n(rst_n), .nv_blank(nv_blank),
      .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .commit_req(commit_req), .commit_idx(commit_idx), .commit_key(commit_key),
      .commit_ack(commit_ack), .chk_valid(chk_valid), .chk_addr(chk_addr),
      .chk_type(chk_type), .chk_allow(chk_allow), .chk_violation(chk_violation),
      .viol_flag(viol_flag)
   );

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;
   logic [31:0] m_live [8];
   logic [31:0] m_shadow [8];
   int unsigned seed = 32'h1234_5678;

   function automatic bit model_ok(logic [31:0] a, logic [1:0] t);
      int unsigned blk  = a >> 11;
      int unsigned bank = (blk >> 5) & 3;
      int unsigned b    = blk & 31;
      bit rd = m_live[bank][b];
      bit pg = m_live[4 + bank][b];
      if (t == 2'd0) return 1'b1;
      if (t == 2'd1) return rd;
      return rd & pg;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle();
      reg_wr = 0; reg_idx = 0; reg_wdata = '0;
      commit_req = 0; commit_idx = 0; commit_key = '0;
      chk_valid = 0; chk_addr = '0; chk_type = 0;
   endtask

   // Inputs are set just after a falling edge; compare, clock, compare.
   task automatic step(string rtag, string atag);
      bit ok, exp_flag, exp_ack, hit;
      logic [31:0] old_live [8];
      logic [31:0] old_sh [8];
      #1;
      ok = model_ok(chk_addr, chk_type);
      if (rst_n) begin
         check(rtag, reg_rdata, m_live[reg_idx]);
         check(atag, {30'd0, chk_allow, chk_violation},
               chk_valid ? {30'd0, ok, !ok} : 32'd0);
      end
      exp_flag = rst_n && chk_valid && !ok;
      hit      = rst_n && commit_req && (commit_key == GOOD_KEY);
      exp_ack  = hit;
      old_live = m_live;
      old_sh   = m_shadow;
      @(posedge clk);
      if (nv_blank) begin
         for (int i = 0; i < 8; i++) m_shadow[i] = '1;
      end else if (hit) begin
         m_shadow[commit_idx] = old_live[commit_idx];
      end
      if (!rst_n) m_live = old_sh;
      else if (reg_wr) m_live[reg_idx] = old_live[reg_idx] & reg_wdata;
      @(negedge clk);
      check("R7", {31'd0, viol_flag}, {31'd0, exp_flag});
      check("R8", {31'd0, commit_ack}, {31'd0, exp_ack});
   endtask

   function automatic string kind_tag(logic [1:0] t);
      if (t == 2'd0) return "R3";
      if (t == 2'd1) return "R4";
      return "R5";
   endfunction

   task automatic rd_reg(logic [2:0] idx, string tag);
      idle(); reg_idx = idx; step(tag, "R7");
   endtask

   task automatic wr_reg(logic [2:0] idx, logic [31:0] d, string tag);
      idle(); reg_wr = 1; reg_idx = idx; reg_wdata = d; step(tag, "R7");
   endtask

   task automatic probe(logic [31:0] a, logic [1:0] t, string tag, bit exp_allow);
      idle(); chk_valid = 1; chk_addr = a; chk_type = t;
      #1;
      check(tag, {31'd0, chk_allow}, {31'd0, exp_allow});
      step("R2", tag);
   endtask

   task automatic commit(logic [2:0] idx, logic [15:0] key);
      idle(); commit_req = 1; commit_idx = idx; commit_key = key;
      step("R2", "R7");
   endtask

   task automatic do_reset(bit blank);
      idle(); rst_n = 0; nv_blank = blank; step("R9", "R7");
      nv_blank = 0; step("R9", "R7");
      rst_n = 1;
   endtask

   function automatic int unsigned rnd();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed >> 8;
   endfunction

   initial begin
      idle(); rst_n = 0; nv_blank = 1;
      @(negedge clk);
      // R10: blank the shadow, then R1 after reset
      do_reset(1'b1);
      for (int i = 0; i < 8; i++) begin
         idle(); reg_idx = 3'(i);
         #1; check("R1", reg_rdata, 32'hFFFF_FFFF);
         step("R1", "R7");
      end
      for (int t = 0; t < 4; t++) probe(32'h0000_2000, 2'(t), "R1", 1'b1);

      // Execute-only with program bit still set: bank0 granule 3
      wr_reg(3'd0, ~(32'd1 << 3), "R2");
      probe(32'd3 * 2048, 2'd0, "R3", 1'b1);
      probe(32'd3 * 2048 + 32'h10, 2'd1, "R4", 1'b0);
      probe(32'd3 * 2048, 2'd2, "R5", 1'b0);
      probe(32'd3 * 2048, 2'd3, "R5", 1'b0);
      // Read-only: bank1 granule 5 (granule 37)
      wr_reg(3'd5, ~(32'd1 << 5), "R2");
      probe(32'd37 * 2048, 2'd1, "R4", 1'b1);
      probe(32'd37 * 2048, 2'd3, "R5", 1'b0);
      probe(32'd36 * 2048, 2'd2, "R5", 1'b1);
      // Bits cannot be set again
      wr_reg(3'd0, 32'hFFFF_FFFF, "R2");
      idle(); reg_idx = 3'd0; #1;
      check("R2", reg_rdata, ~(32'd1 << 3));
      step("R2", "R7");
      // R6: granule 165 lies in bank 5, which aliases to bank 1 bit 5
      probe(32'd165 * 2048, 2'd2, "R6", 1'b0);
      probe(32'd165 * 2048, 2'd1, "R6", 1'b1);
      probe(32'd131 * 2048, 2'd1, "R6", 1'b0);

      // R8: wrong key on read word 0, good key on program word 1
      commit(3'd0, 16'h1234);
      commit(3'd5, GOOD_KEY);
      // R9: reset drops uncommitted word 0 change, keeps committed word 5
      do_reset(1'b0);
      idle(); reg_idx = 3'd0; #1;
      check("R9", reg_rdata, 32'hFFFF_FFFF);
      step("R9", "R7");
      idle(); reg_idx = 3'd5; #1;
      check("R8", reg_rdata, ~(32'd1 << 5));
      step("R8", "R7");
      probe(32'd37 * 2048, 2'd2, "R8", 1'b0);

      // R7: invalid check yields neither answer
      idle(); chk_addr = 32'd37 * 2048; chk_type = 2'd2;
      #1;
      check("R7", {30'd0, chk_allow, chk_violation}, 32'd0);
      step("R2", "R7");

      // Mixed pseudo-random traffic against the model
      for (int n = 0; n < 400; n++) begin
         int unsigned r = rnd();
         idle();
         reg_idx = 3'(r >> 3);
         case (r % 8)
            0: begin reg_wr = 1; reg_wdata = ~(32'd1 << ((r >> 6) % 32)); end
            1: begin commit_req = 1; commit_idx = 3'(r >> 9);
                     commit_key = ((r >> 12) % 2 == 1) ? GOOD_KEY : 16'(r); end
            default: begin
               chk_valid = 1;
               chk_addr  = (rnd() % 1024) * 2048 + (r % 2048);
               chk_type  = 2'(r >> 4);
            end
         endcase
         step("R2", kind_tag(chk_type));
         if (n == 200) do_reset(1'b0);
      end

      // R10: blank then reset returns everything to read/write
      do_reset(1'b1);
      for (int i = 0; i < 8; i++) begin
         idle(); reg_idx = 3'(i);
         #1; check("R10", reg_rdata, 32'hFFFF_FFFF);
         step("R10", "R7");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule